// File: doc/BRIEF.md
# Unrolled AES-128 Encryption Pipeline

This block encrypts 128-bit blocks under 128-bit keys with the AES-128 cipher. Each of the ten cipher rounds sits in its own register stage, behind one stage that performs the initial key addition. The round-key expansion is not precomputed. Each stage derives the next round key from the key it received and passes that key on with the data. Every block in flight therefore carries its own key, and both the plaintext and the key may change on every clock edge.

The input has no back-pressure. When `in_valid` is high at a rising edge, the block and key on the inputs are captured. Exactly eleven edges later, the matching ciphertext appears on `out_block` with `out_valid` high. Gaps in the input stream appear as identical gaps at the output. When the pipeline is full, it delivers one ciphertext per cycle.

Top module: `aes128_unrolled`

## Requirements
- R1: A block captured at rising edge k is presented on `out_block` with `out_valid` high during the cycle after edge k+10, so the latency is a fixed 11 cycles.
- R2: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: A new block is accepted on every edge where `in_valid` is high, with no stall. A run of consecutive valid inputs yields the same number of consecutive valid outputs, in input order.
- R4: Each block is encrypted under the key presented in the same cycle as that block, even when the key differs on every cycle. Identical block and key pairs give identical ciphertexts.
- R5: `out_valid` equals `in_valid` delayed by 11 edges, so idle input cycles show up as idle output cycles.
- R6: A synchronous active-high `rst` clears every stage's valid flag. `out_valid` is low while reset is held and for the first 11 cycles after it, and blocks in flight when reset arrives are never delivered.
- R7: Bits 127:120 of `in_block`, `in_key` and `out_block` hold state byte 0. Bytes fill the state column by column, four bytes per column.
- R8: The cipher applies an initial key addition, then nine full rounds, then a final round without column mixing. The key-expansion steps use round constants 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 in order. With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, the output is 3925841d02dc09fbdc118597196a0b32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Captures `in_block` and `in_key` on this edge |
| in_block | input | 128 | Plaintext block, state byte 0 in bits 127:120 |
| in_key | input | 128 | Cipher key for this block, key byte 0 in bits 127:120 |
| out_valid | output | 1 | `out_block` holds a ciphertext |
| out_block | output | 128 | Ciphertext, state byte 0 in bits 127:120 |

## Verification
The assertions assume that reset is asserted before the first useful edge, because the 11-cycle history they compare against is counted from reset release. They also assume that the data and key inputs carry defined values whenever `in_valid` is high. The bench holds reset for several edges at start-up and again in the middle of the run. It drives zeros on the inputs whenever `in_valid` is low, and it changes inputs only on falling edges. The determinism check assumes nothing about which keys arrive, so the back-to-back stream freely mixes repeated and distinct key and block pairs.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;

    localparam int unsigned AES_BLK_W  = 128;
    localparam int unsigned AES_BYTES  = AES_BLK_W / 8;
    localparam int unsigned AES_WORDS  = AES_BYTES / 4;
    localparam int unsigned AES_ROUNDS = 10;
    localparam int unsigned AES_LAT    = AES_ROUNDS + 1;

    typedef logic [AES_BLK_W-1:0] aes_blk_t;
    typedef logic [7:0]           aes_byte_t;
    typedef logic [31:0]          aes_word_t;

    typedef struct packed {
        logic     vld;
        aes_blk_t st;
        aes_blk_t rk;
    } aes_slot_t;

    function automatic aes_byte_t gf_dbl(input aes_byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic aes_byte_t gf_mul(input aes_byte_t a, input aes_byte_t b);
        aes_byte_t acc;
        aes_byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Inverse by a^254, then the affine map; zero maps to zero before the affine step.
    function automatic aes_byte_t sbox(input aes_byte_t a);
        aes_byte_t sq;
        aes_byte_t inv;
        sq  = gf_mul(a, a);
        inv = sq;
        for (int i = 0; i < 6; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    function automatic aes_byte_t rcon_at(input int unsigned step);
        aes_byte_t r;
        r = 8'h01;
        for (int unsigned i = 1; i < step; i++) r = gf_dbl(r);
        return r;
    endfunction

    function automatic aes_byte_t get_byte(input aes_blk_t blk, input int unsigned k);
        return blk[AES_BLK_W-1-8*k -: 8];
    endfunction

    function automatic aes_word_t sub_word(input aes_word_t w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    function automatic aes_word_t mix_col(input aes_word_t c);
        aes_byte_t a0, a1, a2, a3;
        a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
        return {gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
                gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3)};
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_pipe_pkg::*;
#(
    parameter aes_byte_t RCON = 8'h01
) (
    input  aes_blk_t key_cur,
    output aes_blk_t key_nxt
);
    aes_word_t w [AES_WORDS];
    aes_word_t n [AES_WORDS];
    aes_word_t twist;

    always_comb begin
        for (int i = 0; i < AES_WORDS; i++) w[i] = key_cur[AES_BLK_W-1-32*i -: 32];
        twist = sub_word({w[AES_WORDS-1][23:0], w[AES_WORDS-1][31:24]}) ^ {RCON, 24'h000000};
        n[0] = w[0] ^ twist;
        for (int i = 1; i < AES_WORDS; i++) n[i] = w[i] ^ n[i-1];
        for (int i = 0; i < AES_WORDS; i++) key_nxt[AES_BLK_W-1-32*i -: 32] = n[i];
    end
endmodule

// File: rtl/aes_round_xform.sv
module aes_round_xform
    import aes_pipe_pkg::*;
#(
    parameter bit LAST = 1'b0
) (
    input  aes_blk_t st_in,
    input  aes_blk_t rkey,
    output aes_blk_t st_out
);
    aes_blk_t shifted;
    aes_blk_t mixed;

    // Substitution and row rotation: byte (r,c) takes byte (r,(c+r) mod 4), index r+4c.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                shifted[AES_BLK_W-1-8*(r+4*c) -: 8] = sbox(get_byte(st_in, r + 4*((c+r) % 4)));
            end
        end
    end

    generate
        if (LAST) begin : g_final
            assign mixed = shifted;
        end else begin : g_full
            always_comb begin
                for (int c = 0; c < AES_WORDS; c++) begin
                    mixed[AES_BLK_W-1-32*c -: 32] = mix_col(shifted[AES_BLK_W-1-32*c -: 32]);
                end
            end
        end
    endgenerate

    assign st_out = mixed ^ rkey;
endmodule

// File: rtl/aes_pipe_stage.sv
module aes_pipe_stage
    import aes_pipe_pkg::*;
#(
    parameter aes_byte_t RCON = 8'h01,
    parameter bit        LAST = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  aes_slot_t slot_in,
    output aes_slot_t slot_out
);
    aes_blk_t rk_next;
    aes_blk_t st_next;

    aes_key_step #(.RCON(RCON)) u_key (
        .key_cur (slot_in.rk),
        .key_nxt (rk_next)
    );

    aes_round_xform #(.LAST(LAST)) u_round (
        .st_in  (slot_in.st),
        .rkey   (rk_next),
        .st_out (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_out.vld <= 1'b0;
        end else begin
            slot_out.vld <= slot_in.vld;
        end
        slot_out.st <= st_next;
        slot_out.rk <= rk_next;
    end
endmodule

// File: rtl/aes128_unrolled.sv
module aes128_unrolled
    import aes_pipe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [AES_BLK_W-1:0] in_block,
    input  logic [AES_BLK_W-1:0] in_key,
    output logic                 out_valid,
    output logic [AES_BLK_W-1:0] out_block
);
    aes_slot_t slot [AES_ROUNDS+1];

    // Stage 0: initial key addition.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot[0].vld <= 1'b0;
        end else begin
            slot[0].vld <= in_valid;
        end
        slot[0].st <= in_block ^ in_key;
        slot[0].rk <= in_key;
    end

    generate
        for (genvar g = 1; g <= AES_ROUNDS; g++) begin : g_round
            aes_pipe_stage #(
                .RCON (rcon_at(g)),
                .LAST (g == AES_ROUNDS)
            ) u_stage (
                .clk      (clk),
                .rst      (rst),
                .slot_in  (slot[g-1]),
                .slot_out (slot[g])
            );
        end
    endgenerate

    assign out_valid = slot[AES_ROUNDS].vld;
    assign out_block = slot[AES_ROUNDS].st;
endmodule

// File: rtl/aes128_unrolled_chk.sv
module aes128_unrolled_chk
    import aes_pipe_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [AES_BLK_W-1:0] in_block,
    input logic [AES_BLK_W-1:0] in_key,
    input logic                 out_valid,
    input logic [AES_BLK_W-1:0] out_block
);
    logic [4:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 5'd31) since_rst <= since_rst + 5'd1;
    end

    assert_fixed_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 5'd11) |-> (out_valid == $past(in_valid, 11)));

    assert_gap_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 5'd11 && !$past(in_valid, 11)) |-> !out_valid);

    assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 5'd11) |-> !out_valid);

    assert_same_pair_same_out_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 5'd12 && out_valid && $past(out_valid)
         && $past(in_block, 11) == $past(in_block, 12)
         && $past(in_key, 11) == $past(in_key, 12)) |-> $stable(out_block));
endmodule

bind aes128_unrolled aes128_unrolled_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_block  (in_block),
    .in_key    (in_key),
    .out_valid (out_valid),
    .out_block (out_block)
);

// File: tb/aes128_unrolled_bench.sv
module aes128_unrolled_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_block;
    logic [127:0] in_key;
    logic         out_valid;
    logic [127:0] out_block;

    always #4 clk = ~clk;

    aes128_unrolled u_aes128_unrolled (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
        .in_key(in_key), .out_valid(out_valid), .out_block(out_block)
    );

    typedef struct {
        logic [127:0] exp;
        int           due;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   seen   = 0;
    int   sent   = 0;
    bit   done   = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as ciphertexts leave the pipeline.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "valid output with nothing expected", 128'(out_valid), 128'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_block == e.exp, e.tag, "ciphertext", out_block, e.exp);
                    check(cyc == e.due, "R1", "latency cycle", 128'(cyc), 128'(e.due));
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(1'b0, "R1", "missing output at due cycle", 128'(cyc), 128'(e.due));
            end
        end
    end

    task automatic send(input logic [127:0] k, input logic [127:0] p,
                        input logic [127:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_key   = k;
        in_block = p;
        e.exp = c;
        e.due = cyc + 11;
        e.tag = tag;
        sb.push_back(e);
        sent++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_key   = '0;
            in_block = '0;
        end
    endtask

    localparam logic [127:0] K_A = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P_A = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C_A = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P_B = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C_B = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] P_C = 128'h6bc1bee22e409f96e93d7e117393172a;
    localparam logic [127:0] C_C = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
    localparam logic [127:0] P_D = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
    localparam logic [127:0] C_D = 128'hf5d3d58503b9699de785895a96fdbaaf;
    localparam logic [127:0] C_Z = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    localparam logic [127:0] P_G = 128'hf34481ec3cc627bacd5dc3fb08f273e6;
    localparam logic [127:0] C_G = 128'h0336763e966d92595a567cc9ce537f5e;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seen_before;
        rst = 1'b1; in_valid = 1'b0; in_block = '0; in_key = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6", "out_valid during reset", 128'(out_valid), 128'd0);
        @(negedge clk);
        rst = 1'b0;

        // R6: nothing emerges in the first cycles after release.
        seen_before = seen;
        idle(12);
        check(seen == seen_before, "R6", "outputs after reset release", 128'(seen - seen_before), 128'd0);

        send(K_A, P_A, C_A, "R2");
        idle(14);
        send(K_B, P_B, C_B, "R8");
        idle(14);

        // R3, R4, R7: a new key on every cycle, back to back.
        send(K_A, P_A, C_A, "R4");
        send(K_B, P_C, C_C, "R7");
        send('0,  '0,  C_Z, "R4");
        send(K_B, P_D, C_D, "R7");
        send('0,  P_G, C_G, "R3");
        send(K_B, P_B, C_B, "R3");
        send(K_B, P_B, C_B, "R4");
        idle(14);

        // R5: every other cycle idle.
        send(K_B, P_C, C_C, "R5");
        idle(1);
        send(K_A, P_A, C_A, "R5");
        idle(2);
        send('0,  P_G, C_G, "R5");
        idle(1);
        send(K_B, P_D, C_D, "R5");
        idle(14);

        // R6: blocks in flight at reset are dropped.
        send(K_A, P_A, C_A, "R6");
        send(K_B, P_B, C_B, "R6");
        send('0,  '0,  C_Z, "R6");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sb.delete();
        sent -= 3;
        seen_before = seen;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(15);
        check(seen == seen_before, "R6", "flushed blocks delivered", 128'(seen - seen_before), 128'd0);

        send(K_A, P_A, C_A, "R2");
        idle(14);

        check(sb.size() == 0, "R3", "scoreboard drained", 128'(sb.size()), 128'd0);
        check(seen == sent, "R3", "outputs versus inputs", 128'(seen), 128'(sent));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule